// File: doc/BRIEF.md
# Parallel NOR Flash Identity Probe

This block masters a 16-bit asynchronous parallel NOR flash bus to find out which chip sits on it. A one-cycle start request launches a probe. The block writes the three-word unlock and autoselect command sequence and waits a programmable settling time. It then reads the manufacturer word and, when the vendor is known, the device word. When the device word carries the mirror-family code, it also reads two extended identity words. Whatever path the probe takes, it closes with a read-reset write to word 0 so the flash returns to array-read mode.

The result is a 2-bit vendor class, the raw manufacturer and device words, and a sector count and byte size. The count and size are non-zero only for a fully recognised chip. A single-cycle done pulse marks the moment the results change. All strobe widths, the read access time and the settling time are given in clock cycles, so the block fits any system clock. The vendor codes, the identity codes and the reported geometry are parameters.

Top module: `nor_id_probe`

## Requirements
- R1: After a start request the first three bus writes, in this order, are data 0x00AA to word address 0x555, data 0x0055 to word address 0x2AA, and data 0x0090 to word address 0x555.
- R2: The first read strobe (OE low) begins no earlier than SETTLE_CYC clock cycles after the end of the third command write.
- R3: The manufacturer word is read from word address 0 and the device word from word address 1, both as full 16-bit values. The values read are reported on `mfr_id_o` and `dev_id_o`, and `dev_id_o` is 0 when the device word was not read.
- R4: If the manufacturer word equals neither MFR_AMD nor MFR_INTEL in all 16 bits, the block reports vendor 0 with sector count and size 0. It makes no read after the one at address 0.
- R5: If the device word equals DEV_MIRROR, words 14 and 15 are read in that order. The chip is recognised only when word 14 equals EXT_A and word 15 equals EXT_B. Otherwise vendor 0, sector count 0 and size 0 are reported.
- R6: A device word other than DEV_MIRROR yields vendor 0, sector count 0 and size 0, with no read of words 14 or 15.
- R7: Every probe ends with exactly one write to word address 0, issued after all reads. Its data is 0x00FF when the manufacturer word matched MFR_INTEL, and 0x00F0 otherwise.
- R8: Each bus write holds CE and WE low for exactly WR_PULSE cycles, with address and data stable and the data bus driven throughout.
- R9: Each bus read holds CE and OE low for RD_ACCESS cycles and captures the data bus at the end of the last of them. WE and OE are never low together.
- R10: `done_o` is a one-cycle pulse at the end of each probe. The result outputs change only in that cycle and hold until the next probe completes.
- R11: A start request that arrives while a probe is in progress is ignored: it produces no additional bus cycles and no additional done pulse.
- R12: Vendor class encoding is 0 = unknown, 1 = AMD-style (MFR_AMD), 2 = Intel-style (MFR_INTEL), and 3 is never produced. A recognised chip reports KNOWN_SECTORS and KNOWN_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Probe request, sampled only while idle |
| fl_addr_o | output | AW | Flash word address |
| fl_dq_o | output | 16 | Write data toward the flash |
| fl_dq_oe_o | output | 1 | Drive enable for the data bus during writes |
| fl_dq_i | input | 16 | Read data from the flash |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| vendor_o | output | 2 | Vendor class (0 unknown, 1 AMD-style, 2 Intel-style) |
| mfr_id_o | output | 16 | Manufacturer word read |
| dev_id_o | output | 16 | Device word read, 0 if skipped |
| sectors_o | output | SECT_W | Sector count of a recognised chip, else 0 |
| size_o | output | SIZE_W | Byte size of a recognised chip, else 0 |

## Verification
The bench builds the probe with WR_PULSE=2, RD_ACCESS=3, RECOVER=1 and SETTLE_CYC=20, with a 16-bit address. A probe then lasts under a hundred cycles, so every decision path fits in one short run: unknown vendor, non-mirror device, each extended-word mismatch and both reset commands. It also leaves room for start requests dropped into the command and settling phases. The behavioural flash returns valid data only after RD_ACCESS-1 edges of OE low, so an early sample shows up as a wrong identity. The short settling count makes the read-after-command gap exact to measure.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

    localparam int FL_DW = 16;

    localparam logic [15:0] WADDR_CYC_A   = 16'h0555;
    localparam logic [15:0] WADDR_CYC_B   = 16'h02AA;
    localparam logic [15:0] WOFF_MFR      = 16'd0;
    localparam logic [15:0] WOFF_DEV      = 16'd1;
    localparam logic [15:0] WOFF_XA       = 16'd14;
    localparam logic [15:0] WOFF_XB       = 16'd15;

    localparam logic [FL_DW-1:0] CMD_UNLOCK_A  = 16'h00AA;
    localparam logic [FL_DW-1:0] CMD_UNLOCK_B  = 16'h0055;
    localparam logic [FL_DW-1:0] CMD_AUTOSEL   = 16'h0090;
    localparam logic [FL_DW-1:0] CMD_RST_AMD   = 16'h00F0;
    localparam logic [FL_DW-1:0] CMD_RST_INTEL = 16'h00FF;

    typedef enum logic [1:0] {
        VND_NONE  = 2'd0,
        VND_AMD   = 2'd1,
        VND_INTEL = 2'd2
    } vendor_e;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ACT,
        BUS_REC
    } bus_st_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_WAIT,
        SQ_MFR,
        SQ_DEV,
        SQ_XA,
        SQ_XB,
        SQ_RST
    } seq_st_e;

endpackage

// File: rtl/nor_bus_engine.sv
module nor_bus_engine
    import nor_probe_pkg::*;
#(
    parameter int AW        = 20,
    parameter int WR_PULSE  = 4,
    parameter int RD_ACCESS = 8,
    parameter int RECOVER   = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [FL_DW-1:0] wdat_i,
    output logic             ack_o,
    output logic [FL_DW-1:0] rdat_o,
    output logic [AW-1:0]    fl_addr_o,
    output logic [FL_DW-1:0] fl_dq_o,
    output logic             fl_dq_oe_o,
    input  logic [FL_DW-1:0] fl_dq_i,
    output logic             fl_ce_n_o,
    output logic             fl_we_n_o,
    output logic             fl_oe_n_o
);

    localparam int MAXC = (WR_PULSE > RD_ACCESS) ?
                          ((WR_PULSE > RECOVER) ? WR_PULSE : RECOVER) :
                          ((RD_ACCESS > RECOVER) ? RD_ACCESS : RECOVER);
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        bus_st_e          st;
        logic [CW-1:0]    cnt;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [FL_DW-1:0] wdat;
        logic [FL_DW-1:0] rdat;
    } eng_t;

    eng_t q, d;
    logic act_last;

    always_comb begin
        d        = q;
        ack_o    = 1'b0;
        act_last = q.wr ? (q.cnt == CW'(WR_PULSE - 1))
                        : (q.cnt == CW'(RD_ACCESS - 1));
        case (q.st)
            BUS_IDLE: begin
                if (req_i) begin
                    d.st   = BUS_ACT;
                    d.cnt  = '0;
                    d.wr   = wr_i;
                    d.addr = addr_i;
                    d.wdat = wdat_i;
                end
            end
            BUS_ACT: begin
                if (act_last) begin
                    d.st  = BUS_REC;
                    d.cnt = '0;
                    if (!q.wr) begin
                        d.rdat = fl_dq_i;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            BUS_REC: begin
                if (q.cnt == CW'(RECOVER - 1)) begin
                    ack_o = 1'b1;
                    d.st  = BUS_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: BUS_IDLE, cnt: '0, wr: 1'b0, addr: '0, wdat: '0, rdat: '0};
        end else begin
            q <= d;
        end
    end

    assign rdat_o     = q.rdat;
    assign fl_addr_o  = q.addr;
    assign fl_dq_o    = q.wdat;
    assign fl_dq_oe_o = (q.st != BUS_IDLE) && q.wr;
    assign fl_ce_n_o  = (q.st != BUS_ACT);
    assign fl_we_n_o  = !((q.st == BUS_ACT) && q.wr);
    assign fl_oe_n_o  = !((q.st == BUS_ACT) && !q.wr);

endmodule

// File: rtl/nor_id_match.sv
module nor_id_match
    import nor_probe_pkg::*;
#(
    parameter logic [FL_DW-1:0] MFR_AMD    = 16'h0001,
    parameter logic [FL_DW-1:0] MFR_INTEL  = 16'h0089,
    parameter logic [FL_DW-1:0] DEV_MIRROR = 16'h227E,
    parameter logic [FL_DW-1:0] EXT_A      = 16'h2210,
    parameter logic [FL_DW-1:0] EXT_B      = 16'h2201
) (
    input  logic [FL_DW-1:0] rd_i,
    output vendor_e          rd_class_o,
    output logic             rd_mirror_o,
    output logic             rd_ext_a_o,
    output logic             rd_ext_b_o
);

    always_comb begin
        if (rd_i == MFR_AMD) begin
            rd_class_o = VND_AMD;
        end else if (rd_i == MFR_INTEL) begin
            rd_class_o = VND_INTEL;
        end else begin
            rd_class_o = VND_NONE;
        end
        rd_mirror_o = (rd_i == DEV_MIRROR);
        rd_ext_a_o  = (rd_i == EXT_A);
        rd_ext_b_o  = (rd_i == EXT_B);
    end

endmodule

// File: rtl/nor_probe_seq.sv
module nor_probe_seq
    import nor_probe_pkg::*;
#(
    parameter int                AW            = 20,
    parameter int                SETTLE_CYC    = 10000,
    parameter int                SECT_W        = 16,
    parameter int                SIZE_W        = 32,
    parameter logic [SECT_W-1:0] KNOWN_SECTORS = 128,
    parameter logic [SIZE_W-1:0] KNOWN_BYTES   = 32'h0080_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic              req_o,
    output logic              wr_o,
    output logic [AW-1:0]     addr_o,
    output logic [FL_DW-1:0]  wdat_o,
    input  logic              ack_i,
    input  logic [FL_DW-1:0]  rdat_i,
    input  vendor_e           rd_class_i,
    input  logic              rd_mirror_i,
    input  logic              rd_ext_a_i,
    input  logic              rd_ext_b_i,
    output logic              done_o,
    output vendor_e           vendor_o,
    output logic [FL_DW-1:0]  mfr_id_o,
    output logic [FL_DW-1:0]  dev_id_o,
    output logic [SECT_W-1:0] sectors_o,
    output logic [SIZE_W-1:0] size_o
);

    localparam int WCW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        step;
        logic [WCW-1:0]    wcnt;
        logic              pend;
        vendor_e           cls;
        logic              xa_ok;
        logic              known;
        logic [FL_DW-1:0]  mfr;
        logic [FL_DW-1:0]  dev;
        logic              done;
        vendor_e           res_vnd;
        logic [FL_DW-1:0]  res_mfr;
        logic [FL_DW-1:0]  res_dev;
        logic [SECT_W-1:0] res_sect;
        logic [SIZE_W-1:0] res_size;
    } seq_t;

    seq_t q, d;
    logic on_bus;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        wr_o   = 1'b0;
        addr_o = '0;
        wdat_o = '0;
        on_bus = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start_i) begin
                    d.st    = SQ_CMD;
                    d.step  = 2'd0;
                    d.pend  = 1'b0;
                    d.cls   = VND_NONE;
                    d.xa_ok = 1'b0;
                    d.known = 1'b0;
                    d.mfr   = '0;
                    d.dev   = '0;
                end
            end
            SQ_CMD: begin
                on_bus = 1'b1;
                wr_o   = 1'b1;
                case (q.step)
                    2'd0: begin
                        addr_o = AW'(WADDR_CYC_A);
                        wdat_o = CMD_UNLOCK_A;
                    end
                    2'd1: begin
                        addr_o = AW'(WADDR_CYC_B);
                        wdat_o = CMD_UNLOCK_B;
                    end
                    default: begin
                        addr_o = AW'(WADDR_CYC_A);
                        wdat_o = CMD_AUTOSEL;
                    end
                endcase
                if (ack_i) begin
                    if (q.step == 2'd2) begin
                        d.st   = SQ_WAIT;
                        d.wcnt = '0;
                    end else begin
                        d.step = q.step + 2'd1;
                    end
                end
            end
            SQ_WAIT: begin
                if (q.wcnt == WCW'(SETTLE_CYC - 1)) begin
                    d.st = SQ_MFR;
                end else begin
                    d.wcnt = q.wcnt + 1'b1;
                end
            end
            SQ_MFR: begin
                on_bus = 1'b1;
                addr_o = AW'(WOFF_MFR);
                if (ack_i) begin
                    d.mfr = rdat_i;
                    d.cls = rd_class_i;
                    d.st  = (rd_class_i == VND_NONE) ? SQ_RST : SQ_DEV;
                end
            end
            SQ_DEV: begin
                on_bus = 1'b1;
                addr_o = AW'(WOFF_DEV);
                if (ack_i) begin
                    d.dev = rdat_i;
                    d.st  = rd_mirror_i ? SQ_XA : SQ_RST;
                end
            end
            SQ_XA: begin
                on_bus = 1'b1;
                addr_o = AW'(WOFF_XA);
                if (ack_i) begin
                    d.xa_ok = rd_ext_a_i;
                    d.st    = SQ_XB;
                end
            end
            SQ_XB: begin
                on_bus = 1'b1;
                addr_o = AW'(WOFF_XB);
                if (ack_i) begin
                    d.known = q.xa_ok && rd_ext_b_i;
                    d.st    = SQ_RST;
                end
            end
            SQ_RST: begin
                on_bus = 1'b1;
                wr_o   = 1'b1;
                addr_o = AW'(WOFF_MFR);
                wdat_o = (q.cls == VND_INTEL) ? CMD_RST_INTEL : CMD_RST_AMD;
                if (ack_i) begin
                    d.st       = SQ_IDLE;
                    d.done     = 1'b1;
                    d.res_vnd  = q.known ? q.cls : VND_NONE;
                    d.res_mfr  = q.mfr;
                    d.res_dev  = q.dev;
                    d.res_sect = q.known ? KNOWN_SECTORS : '0;
                    d.res_size = q.known ? KNOWN_BYTES : '0;
                end
            end
            default: d.st = SQ_IDLE;
        endcase

        req_o = on_bus && !q.pend;
        if (req_o) begin
            d.pend = 1'b1;
        end
        if (ack_i) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: SQ_IDLE, step: 2'd0, wcnt: '0, pend: 1'b0, cls: VND_NONE,
                   xa_ok: 1'b0, known: 1'b0, mfr: '0, dev: '0, done: 1'b0,
                   res_vnd: VND_NONE, res_mfr: '0, res_dev: '0, res_sect: '0,
                   res_size: '0};
        end else begin
            q <= d;
        end
    end

    assign done_o    = q.done;
    assign vendor_o  = q.res_vnd;
    assign mfr_id_o  = q.res_mfr;
    assign dev_id_o  = q.res_dev;
    assign sectors_o = q.res_sect;
    assign size_o    = q.res_size;

endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
    import nor_probe_pkg::*;
#(
    parameter int                AW            = 20,
    parameter int                WR_PULSE      = 4,
    parameter int                RD_ACCESS     = 8,
    parameter int                RECOVER       = 2,
    parameter int                SETTLE_CYC    = 10000,
    parameter logic [15:0]       MFR_AMD       = 16'h0001,
    parameter logic [15:0]       MFR_INTEL     = 16'h0089,
    parameter logic [15:0]       DEV_MIRROR    = 16'h227E,
    parameter logic [15:0]       EXT_A         = 16'h2210,
    parameter logic [15:0]       EXT_B         = 16'h2201,
    parameter int                SECT_W        = 16,
    parameter int                SIZE_W        = 32,
    parameter logic [SECT_W-1:0] KNOWN_SECTORS = 128,
    parameter logic [SIZE_W-1:0] KNOWN_BYTES   = 32'h0080_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    output logic [AW-1:0]     fl_addr_o,
    output logic [15:0]       fl_dq_o,
    output logic              fl_dq_oe_o,
    input  logic [15:0]       fl_dq_i,
    output logic              fl_ce_n_o,
    output logic              fl_we_n_o,
    output logic              fl_oe_n_o,
    output logic              done_o,
    output logic [1:0]        vendor_o,
    output logic [15:0]       mfr_id_o,
    output logic [15:0]       dev_id_o,
    output logic [SECT_W-1:0] sectors_o,
    output logic [SIZE_W-1:0] size_o
);

    logic             b_req, b_wr, b_ack;
    logic [AW-1:0]    b_addr;
    logic [FL_DW-1:0] b_wdat, b_rdat;
    vendor_e          rd_class, res_vnd;
    logic             rd_mirror, rd_ext_a, rd_ext_b;

    nor_bus_engine #(
        .AW(AW), .WR_PULSE(WR_PULSE), .RD_ACCESS(RD_ACCESS), .RECOVER(RECOVER)
    ) u_bus (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .req_i(b_req), .wr_i(b_wr), .addr_i(b_addr), .wdat_i(b_wdat),
        .ack_o(b_ack), .rdat_o(b_rdat),
        .fl_addr_o(fl_addr_o), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe_o),
        .fl_dq_i(fl_dq_i), .fl_ce_n_o(fl_ce_n_o), .fl_we_n_o(fl_we_n_o),
        .fl_oe_n_o(fl_oe_n_o)
    );

    nor_id_match #(
        .MFR_AMD(MFR_AMD), .MFR_INTEL(MFR_INTEL), .DEV_MIRROR(DEV_MIRROR),
        .EXT_A(EXT_A), .EXT_B(EXT_B)
    ) u_match (
        .rd_i(b_rdat), .rd_class_o(rd_class), .rd_mirror_o(rd_mirror),
        .rd_ext_a_o(rd_ext_a), .rd_ext_b_o(rd_ext_b)
    );

    nor_probe_seq #(
        .AW(AW), .SETTLE_CYC(SETTLE_CYC), .SECT_W(SECT_W), .SIZE_W(SIZE_W),
        .KNOWN_SECTORS(KNOWN_SECTORS), .KNOWN_BYTES(KNOWN_BYTES)
    ) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
        .req_o(b_req), .wr_o(b_wr), .addr_o(b_addr), .wdat_o(b_wdat),
        .ack_i(b_ack), .rdat_i(b_rdat),
        .rd_class_i(rd_class), .rd_mirror_i(rd_mirror),
        .rd_ext_a_i(rd_ext_a), .rd_ext_b_i(rd_ext_b),
        .done_o(done_o), .vendor_o(res_vnd), .mfr_id_o(mfr_id_o),
        .dev_id_o(dev_id_o), .sectors_o(sectors_o), .size_o(size_o)
    );

    assign vendor_o = res_vnd;

endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
    parameter int AW       = 20,
    parameter int SECT_W   = 16,
    parameter int SIZE_W   = 32,
    parameter int WR_PULSE = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [AW-1:0]     fl_addr_o,
    input logic [15:0]       fl_dq_o,
    input logic              fl_dq_oe_o,
    input logic              fl_ce_n_o,
    input logic              fl_we_n_o,
    input logic              fl_oe_n_o,
    input logic              done_o,
    input logic [1:0]        vendor_o,
    input logic [SECT_W-1:0] sectors_o,
    input logic [SIZE_W-1:0] size_o
);

    int we_lo_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            we_lo_cnt <= 0;
        end else if (!fl_we_n_o) begin
            we_lo_cnt <= we_lo_cnt + 1;
        end else begin
            we_lo_cnt <= 0;
        end
    end

    p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!fl_we_n_o && !fl_oe_n_o));

    p_we_with_ce_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fl_we_n_o |-> (!fl_ce_n_o && fl_dq_oe_o));

    p_write_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fl_we_n_o && $past(!fl_we_n_o)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));

    p_write_width_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fl_we_n_o) |-> (we_lo_cnt == WR_PULSE));

    p_read_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fl_oe_n_o && $past(!fl_oe_n_o)) |-> $stable(fl_addr_o));

    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(vendor_o) && $stable(sectors_o) && $stable(size_o)));

    p_unknown_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && vendor_o == 2'd0) |-> (sectors_o == '0 && size_o == '0));

    p_vendor_code_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vendor_o != 2'd3);

endmodule

bind nor_id_probe nor_id_probe_chk #(
    .AW(AW), .SECT_W(SECT_W), .SIZE_W(SIZE_W), .WR_PULSE(WR_PULSE)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .fl_addr_o(fl_addr_o), .fl_dq_o(fl_dq_o),
    .fl_dq_oe_o(fl_dq_oe_o), .fl_ce_n_o(fl_ce_n_o), .fl_we_n_o(fl_we_n_o),
    .fl_oe_n_o(fl_oe_n_o), .done_o(done_o), .vendor_o(vendor_o),
    .sectors_o(sectors_o), .size_o(size_o)
);

// File: tb/sim_nor_id_probe.sv
module sim_nor_id_probe;

    localparam int AW     = 16;
    localparam int WRP    = 2;
    localparam int RDA    = 3;
    localparam int REC    = 1;
    localparam int SETTLE = 20;
    localparam logic [15:0] KSECT = 16'd128;
    localparam logic [31:0] KSIZE = 32'h0080_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] fl_addr;
    logic [15:0]   fl_dq_o, fl_dq_i;
    logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, done;
    logic [1:0]    vendor;
    logic [15:0]   mfr_id, dev_id, sectors;
    logic [31:0]   size;

    nor_id_probe #(
        .AW(AW), .WR_PULSE(WRP), .RD_ACCESS(RDA), .RECOVER(REC), .SETTLE_CYC(SETTLE)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe),
        .fl_dq_i(fl_dq_i), .fl_ce_n_o(fl_ce_n), .fl_we_n_o(fl_we_n),
        .fl_oe_n_o(fl_oe_n), .done_o(done), .vendor_o(vendor),
        .mfr_id_o(mfr_id), .dev_id_o(dev_id), .sectors_o(sectors), .size_o(size)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // behavioural flash
    logic [15:0] m_mfr, m_dev, m_xa, m_xb;
    logic        id_mode = 1'b0;
    int          oe_cnt  = 0;

    always @(posedge clk) oe_cnt <= fl_oe_n ? 0 : oe_cnt + 1;

    function automatic logic [15:0] flash_word(input logic [AW-1:0] a);
        if (!id_mode) return 16'h1234;
        case (a)
            16'd0:   return m_mfr;
            16'd1:   return m_dev;
            16'd14:  return m_xa;
            16'd15:  return m_xb;
            default: return 16'hFFFF;
        endcase
    endfunction

    assign fl_dq_i = (!fl_oe_n && oe_cnt >= RDA - 1) ? flash_word(fl_addr) : 16'hDEAD;

    // bus log
    logic [15:0] wr_a [256];
    logic [15:0] wr_d [256];
    int          wr_len [256];
    bit          wr_stab [256];
    int          wr_end [256];
    logic [15:0] rd_a [256];
    int          rd_t [256];
    int          nw = 0, nr = 0;
    int          we_lo = 0;
    logic [15:0] cur_a, cur_d;
    bit          cur_stab;
    logic        oe_prev = 1'b1;

    always @(negedge clk) begin
        if (!fl_we_n) begin
            if (we_lo == 0) begin
                cur_a = fl_addr; cur_d = fl_dq_o; cur_stab = fl_dq_oe;
            end else if (fl_addr != cur_a || fl_dq_o != cur_d || !fl_dq_oe || fl_ce_n) begin
                cur_stab = 1'b0;
            end
            we_lo++;
        end else if (we_lo != 0) begin
            if (nw < 256) begin
                wr_a[nw] = cur_a; wr_d[nw] = cur_d; wr_len[nw] = we_lo;
                wr_stab[nw] = cur_stab; wr_end[nw] = cyc;
                nw++;
            end
            if (cur_d == 16'h0090) id_mode = 1'b1;
            if (cur_d == 16'h00F0 || cur_d == 16'h00FF) id_mode = 1'b0;
            we_lo = 0;
        end
        if (!fl_oe_n && oe_prev && nr < 256) begin
            rd_a[nr] = fl_addr; rd_t[nr] = cyc; nr++;
        end
        oe_prev = fl_oe_n;
    end

    typedef struct packed {
        logic [15:0] mfr;
        logic [15:0] dev;
        logic [15:0] xa;
        logic [15:0] xb;
        logic [1:0]  vnd;
        logic [2:0]  nrd;
        logic [15:0] rst;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'h0001, 16'h227E, 16'h2210, 16'h2201, 2'd1, 3'd4, 16'h00F0},
        '{16'h0089, 16'h227E, 16'h2210, 16'h2201, 2'd2, 3'd4, 16'h00FF},
        '{16'h00C2, 16'h227E, 16'h2210, 16'h2201, 2'd0, 3'd1, 16'h00F0},
        '{16'h0001, 16'h22F9, 16'h2210, 16'h2201, 2'd0, 3'd2, 16'h00F0},
        '{16'h0001, 16'h227E, 16'h2211, 16'h2201, 2'd0, 3'd4, 16'h00F0},
        '{16'h0089, 16'h227E, 16'h2210, 16'h2200, 2'd0, 3'd4, 16'h00FF},
        '{16'h0101, 16'h227E, 16'h2210, 16'h2201, 2'd0, 3'd1, 16'h00F0},
        '{16'h0089, 16'h2257, 16'h2210, 16'h2201, 2'd0, 3'd2, 16'h00FF}
    };

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int w0, r0, n_done, bad, gap;
        logic [15:0] exp_ra [4];
        logic [15:0] exp_dev;
        exp_ra = '{16'd0, 16'd1, 16'd14, 16'd15};
        m_mfr = v.mfr; m_dev = v.dev; m_xa = v.xa; m_xb = v.xb;
        @(negedge clk);
        w0 = nw; r0 = nr; n_done = 0;
        pulse_start();
        for (int k = 0; k < 2000 && n_done == 0; k++) begin
            if (done) n_done++;
            else @(negedge clk);
        end
        chk("R10", $sformatf("v%0d done seen", idx), 64'(n_done), 64'd1);
        chk("R12", $sformatf("v%0d vendor", idx), 64'(vendor), 64'(v.vnd));
        chk("R5", $sformatf("v%0d sectors", idx), 64'(sectors),
            (v.vnd != 2'd0) ? 64'(KSECT) : 64'd0);
        chk("R4", $sformatf("v%0d size", idx), 64'(size),
            (v.vnd != 2'd0) ? 64'(KSIZE) : 64'd0);
        chk("R3", $sformatf("v%0d mfr id", idx), 64'(mfr_id), 64'(v.mfr));
        exp_dev = (v.nrd >= 3'd2) ? v.dev : 16'd0;
        chk("R3", $sformatf("v%0d dev id", idx), 64'(dev_id), 64'(exp_dev));
        chk("R6", $sformatf("v%0d read count", idx), 64'(nr - r0), 64'(v.nrd));
        for (int k = 0; k < int'(v.nrd) && r0 + k < nr; k++)
            chk("R5", $sformatf("v%0d read %0d addr", idx, k), 64'(rd_a[r0+k]), 64'(exp_ra[k]));
        chk("R1", $sformatf("v%0d write count", idx), 64'(nw - w0), 64'd4);
        chk("R1", $sformatf("v%0d cmd0", idx), {32'd0, wr_a[w0], wr_d[w0]}, 64'h0555_00AA);
        chk("R1", $sformatf("v%0d cmd1", idx), {32'd0, wr_a[w0+1], wr_d[w0+1]}, 64'h02AA_0055);
        chk("R1", $sformatf("v%0d cmd2", idx), {32'd0, wr_a[w0+2], wr_d[w0+2]}, 64'h0555_0090);
        chk("R7", $sformatf("v%0d reset write", idx), {32'd0, wr_a[w0+3], wr_d[w0+3]},
            {48'd0, v.rst});
        chk("R7", $sformatf("v%0d reset after reads", idx),
            64'(wr_end[w0+3] > rd_t[nr-1]), 64'd1);
        gap = rd_t[r0] - wr_end[w0+2];
        chk("R2", $sformatf("v%0d settle gap %0d", idx, gap), 64'(gap >= SETTLE), 64'd1);
        bad = 0;
        for (int k = w0; k < nw; k++)
            if (wr_len[k] != WRP || !wr_stab[k]) bad++;
        chk("R8", $sformatf("v%0d bad write strobes", idx), 64'(bad), 64'd0);
        @(negedge clk);
        chk("R10", $sformatf("v%0d done single cycle", idx), 64'(done), 64'd0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        m_mfr = '0; m_dev = '0; m_xa = '0; m_xb = '0;
        repeat (3) @(negedge clk);
        chk("R9", "strobes in reset", {61'd0, fl_ce_n, fl_we_n, fl_oe_n}, 64'd7);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "results after reset", {vendor, sectors, size}, 64'd0);
        chk("R8", "bus idle after reset", {61'd0, fl_dq_oe, done, fl_ce_n}, 64'd1);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R11: start requests during a probe are ignored
        begin
            int w0, r0, n_done;
            m_mfr = 16'h0089; m_dev = 16'h227E; m_xa = 16'h2210; m_xb = 16'h2201;
            w0 = nw; r0 = nr; n_done = 0;
            pulse_start();
            repeat (4) @(negedge clk);
            pulse_start();
            repeat (15) @(negedge clk);
            pulse_start();
            for (int k = 0; k < 300; k++) begin
                if (done) n_done++;
                @(negedge clk);
            end
            chk("R11", "done pulses with repeated start", 64'(n_done), 64'd1);
            chk("R11", "writes with repeated start", 64'(nw - w0), 64'd4);
            chk("R11", "reads with repeated start", 64'(nr - r0), 64'd4);
            chk("R10", "vendor held after probe", 64'(vendor), 64'd2);
            chk("R10", "sectors held after probe", 64'(sectors), 64'(KSECT));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule